// File: doc/BRIEF.md
# Timer Input Capture Unit with Event Prescaler

This block takes a snapshot of one of two free-running 16-bit timers whenever a chosen event occurs, and raises a sticky interrupt flag. The event comes either from an asynchronous capture pin, which is synchronized and edge-detected inside the block, or from a synchronous message-received strobe. The strobe lets received messages be timestamped.

A 4-bit mode field turns capture on and picks the event type. It can capture on each falling edge, on each rising edge, on every 4th rising edge or on every 16th rising edge. A free-running 4-bit prescaler counts qualifying events. It is cleared only when the mode field leaves the capture range or on reset, so moving between prescaler settings keeps the partial count. Software reads the captured value and clears the flag with a one-cycle strobe. A value that is not read in time is overwritten.

Top module: `capture_unit`

## Requirements
- R1: After reset (rst_n low, asynchronous) cap_val is 0, cap_flag is 0 and the prescaler count is 0.
- R2: When a capture occurs, cap_val on the next cycle holds the selected timer value that was present in the cycle the event was detected, and cap_flag is 1 on that next cycle.
- R3: cap_pin passes through a two-flop synchronizer followed by an edge detector. A pin change driven before clock edge k is captured at edge k+2, the third rising edge.
- R4: With alt_src low, mode 4'b0100 captures on each falling pin edge and mode 4'b0101 on each rising pin edge. The opposite edge has no effect.
- R5: Mode 4'b0110 captures on every 4th qualifying event and mode 4'b0111 on every 16th, counted by a 4-bit prescaler that increments on each event.
- R6: Any mode value outside 4'b0100 to 4'b0111 captures nothing, leaves cap_val and cap_flag unchanged and clears the prescaler.
- R7: Switching directly between capture modes keeps the prescaler count. For example, 2 events in mode 4'b0110 followed by a switch to 4'b0111 make the 14th further event capture.
- R8: cap_flag stays set until a flag_clr pulse. A capture in the same cycle as flag_clr leaves the flag set.
- R9: A new capture overwrites cap_val even if the flag was never cleared.
- R10: With alt_src high, each cycle with msg_rx high is one event and the pin is ignored. Modes 4'b0100 and 4'b0101 capture on every message, 4'b0110 on every 4th and 4'b0111 on every 16th.
- R11: tmr_sel 0 captures tmr_a and tmr_sel 1 captures tmr_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Capture mode field |
| tmr_sel | input | 1 | Timer select: 0 = tmr_a, 1 = tmr_b |
| tmr_a | input | 16 | First synchronous timer value |
| tmr_b | input | 16 | Second synchronous timer value |
| cap_pin | input | 1 | Asynchronous capture pin |
| msg_rx | input | 1 | Synchronous message-received strobe |
| alt_src | input | 1 | Use msg_rx instead of cap_pin as event source |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_val | output | 16 | Captured timer value |
| cap_flag | output | 1 | Sticky capture interrupt flag |

## Verification
The prescaler count is the only hidden state. If it is wrong, a capture arrives too early or too late, so cap_flag rises on the wrong event. That shows at the ports within at most 16 events. This is why the bench places captures after mode switches and after returns from the off modes. A wrong synchronizer depth or a wrong edge polarity shifts the capture by a clock or by a half pin period, and the per-cycle model comparison sees that on the first event. A wrong timer select or a missing overwrite shows in cap_val one cycle after the capture.

// File: rtl/capture_unit.sv
module capture_unit #(
  parameter int TW   = 16,
  parameter int SYNC = 2,
  parameter int PSW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          tmr_sel,
  input  logic [TW-1:0] tmr_a,
  input  logic [TW-1:0] tmr_b,
  input  logic          cap_pin,
  input  logic          msg_rx,
  input  logic          alt_src,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_val,
  output logic          cap_flag
);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic [PSW-1:0]  presc;
  logic            due;

  wire pin_s    = sync_q[SYNC-1];
  wire rise     = pin_s & ~prev_q;
  wire fall     = ~pin_s & prev_q;
  wire cap_mode = (mode[3:2] == 2'b01);
  wire src_ev   = alt_src ? msg_rx : ((mode[1:0] == 2'b00) ? fall : rise);
  wire ev       = cap_mode & src_ev;
  wire cap_now  = ev & due;
  wire [TW-1:0] tmr_pick = tmr_sel ? tmr_b : tmr_a;

  always_comb begin
    case (mode[1:0])
      2'b10:   due = &presc[1:0];
      2'b11:   due = &presc;
      default: due = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], cap_pin};
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         presc <= '0;
    else if (!cap_mode) presc <= '0;
    else if (ev)        presc <= presc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
    end else begin
      if (cap_now) cap_val <= tmr_pick;
      cap_flag <= cap_now | (cap_flag & ~flag_clr);
    end
  end

endmodule

// File: rtl/capture_unit_chk.sv
module capture_unit_chk #(
  parameter int TW  = 16,
  parameter int PSW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode,
  input logic          tmr_sel,
  input logic [TW-1:0] tmr_a,
  input logic [TW-1:0] tmr_b,
  input logic          msg_rx,
  input logic          alt_src,
  input logic          flag_clr,
  input logic [TW-1:0] cap_val,
  input logic          cap_flag,
  input logic [PSW-1:0] presc,
  input logic          cap_now
);

  always @(posedge clk) if (!rst_n) AST_RESET_STATE: assert (cap_val == '0 && !cap_flag && presc == '0); // R1

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_now |=> (cap_flag && cap_val == $past(tmr_sel ? tmr_b : tmr_a))); // R2

  AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_now |=> $stable(cap_val)); // R9

  AST_OFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |-> !cap_now); // R6

  AST_OFF_CLEARS_PRESC: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[3:2] != 2'b01) |=> (presc == '0)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr) |=> cap_flag); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !cap_now) |=> !cap_flag); // R8

  AST_ALT_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_src && !msg_rx) |-> !cap_now); // R10

endmodule

bind capture_unit capture_unit_chk #(.TW(TW), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tmr_sel(tmr_sel),
  .tmr_a(tmr_a), .tmr_b(tmr_b), .msg_rx(msg_rx), .alt_src(alt_src),
  .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag),
  .presc(presc), .cap_now(cap_now)
);

// File: tb/capture_unit_tb.sv
module capture_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  mode = 0;
  logic        tmr_sel = 0;
  logic [15:0] tmr_a = 16'h0100;
  logic [15:0] tmr_b = 16'hF000;
  logic        cap_pin = 0, msg_rx = 0, alt_src = 0, flag_clr = 0;
  logic [15:0] cap_val;
  logic        cap_flag;

  int checks = 0, errors = 0;
  bit done = 0, trun = 1;

  // reference model state
  bit p1, p2, p3, m_flag;
  int m_cnt;
  logic [15:0] m_val;

  capture_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tmr_sel(tmr_sel),
    .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_pin(cap_pin), .msg_rx(msg_rx),
    .alt_src(alt_src), .flag_clr(flag_clr), .cap_val(cap_val), .cap_flag(cap_flag)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (trun) begin
    tmr_a <= tmr_a + 16'd1;
    tmr_b <= tmr_b - 16'd3;
  end

  always @(posedge clk) begin
    bit on, ev, cap;
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0; m_flag = 0; m_cnt = 0; m_val = 0;
    end else begin
      on = (mode >= 4 && mode <= 7);
      if (alt_src) ev = msg_rx;
      else if (mode == 4) ev = !p2 && p3;
      else ev = p2 && !p3;
      ev = ev && on;
      cap = 0;
      if (!on) m_cnt = 0;
      else if (ev) begin
        if (mode == 6) cap = (m_cnt % 4) == 3;
        else if (mode == 7) cap = (m_cnt == 15);
        else cap = 1;
        m_cnt = (m_cnt + 1) % 16;
      end
      if (cap) begin
        m_val = tmr_sel ? tmr_b : tmr_a;
        m_flag = 1;
      end else if (flag_clr) m_flag = 0;
      p3 = p2; p2 = p1; p1 = cap_pin;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 model cap_val", {16'd0, cap_val}, {16'd0, m_val});
    chk("R8 model cap_flag", {31'd0, cap_flag}, {31'd0, m_flag});
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_to(input logic v);
    cap_pin = v;
    tick(4);
  endtask

  task automatic pulse_pin();
    pin_to(1);
    pin_to(0);
  endtask

  task automatic clr();
    flag_clr = 1; tick(1); flag_clr = 0;
  endtask

  task automatic msg(input int n);
    msg_rx = 1; tick(n); msg_rx = 0; tick(1);
  endtask

  initial begin
    logic [15:0] held;
    tick(3);
    chk("R1 reset cap_val", {16'd0, cap_val}, 0);
    chk("R1 reset cap_flag", {31'd0, cap_flag}, 0);
    rst_n = 1; tick(1);

    mode = 4'b0101;
    pin_to(1);
    chk("R4 rising captures", {31'd0, cap_flag}, 1);
    tick(5);
    chk("R8 flag sticky", {31'd0, cap_flag}, 1);
    clr();
    chk("R8 flag cleared", {31'd0, cap_flag}, 0);
    pin_to(0);
    chk("R4 falling ignored in 0101", {31'd0, cap_flag}, 0);

    mode = 4'b0100; tick(1); clr();
    pin_to(1);
    chk("R4 rising ignored in 0100", {31'd0, cap_flag}, 0);
    pin_to(0);
    chk("R4 falling captures", {31'd0, cap_flag}, 1);
    clr();

    mode = 4'b0000; tick(1); mode = 4'b0110;
    repeat (3) pulse_pin();
    chk("R5 div4 no capture after 3", {31'd0, cap_flag}, 0);
    pulse_pin();
    chk("R5 div4 capture on 4th", {31'd0, cap_flag}, 1);
    clr();

    mode = 4'b0000; tick(1); mode = 4'b0110;
    repeat (2) pulse_pin();
    mode = 4'b0000; tick(1); mode = 4'b0110;
    repeat (3) pulse_pin();
    chk("R6 off cleared prescaler", {31'd0, cap_flag}, 0);
    pulse_pin();
    chk("R6 capture after fresh 4", {31'd0, cap_flag}, 1);
    clr();

    mode = 4'b0000; tick(1); mode = 4'b0110;
    repeat (2) pulse_pin();
    mode = 4'b0111; tick(1); clr();
    repeat (13) pulse_pin();
    chk("R7 no capture after 13", {31'd0, cap_flag}, 0);
    pulse_pin();
    chk("R7 kept count, capture on 14th", {31'd0, cap_flag}, 1);
    clr();

    mode = 4'b0000; held = cap_val;
    repeat (2) pulse_pin();
    chk("R6 mode 0000 no flag", {31'd0, cap_flag}, 0);
    chk("R6 mode 0000 value held", {16'd0, cap_val}, {16'd0, held});
    mode = 4'b1101;
    repeat (2) pulse_pin();
    chk("R6 mode 1101 no flag", {31'd0, cap_flag}, 0);
    chk("R6 mode 1101 value held", {16'd0, cap_val}, {16'd0, held});

    mode = 4'b0101; alt_src = 1; tick(1);
    pin_to(1);
    chk("R10 pin ignored", {31'd0, cap_flag}, 0);
    pin_to(0);
    msg(1);
    chk("R10 message captures in 0101", {31'd0, cap_flag}, 1);
    clr();
    mode = 4'b0100; tick(1);
    msg(1);
    chk("R10 message captures in 0100", {31'd0, cap_flag}, 1);
    clr();
    mode = 4'b0000; tick(1); mode = 4'b0110;
    msg(3);
    chk("R10 div4 after 3 messages", {31'd0, cap_flag}, 0);
    msg(1);
    chk("R10 div4 on 4th message", {31'd0, cap_flag}, 1);
    clr();

    mode = 4'b0101; trun = 0;
    tmr_a <= 16'h1234; tmr_b <= 16'hBEEF; tmr_sel = 1; tick(1);
    msg(1);
    chk("R11 tmr_b selected", {16'd0, cap_val}, 32'hBEEF);
    tmr_sel = 0;
    msg(1);
    chk("R9 overwrite with tmr_a", {16'd0, cap_val}, 32'h1234);
    chk("R2 flag set", {31'd0, cap_flag}, 1);
    clr();
    flag_clr = 1; msg_rx = 1; tick(1); flag_clr = 0; msg_rx = 0;
    chk("R8 capture beats clear", {31'd0, cap_flag}, 1);

    alt_src = 0; trun = 1; clr(); tick(3);
    cap_pin = 1; tick(2);
    chk("R3 no capture after 2 edges", {31'd0, cap_flag}, 0);
    tick(1);
    chk("R3 capture at 3rd edge", {31'd0, cap_flag}, 1);
    tick(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1-chain hung actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule